// File: doc/BRIEF.md
# Data-Space Register File with Pointer Indirection

This block holds the 32-location data space of a small 8-bit controller. A 5-bit address selects a pointer-dereference slot, a view of the program counter's low byte, the flag/status byte, the pointer register, two port data latches and 25 general-purpose bytes. One read port is combinational and one write port updates storage on the rising clock edge, so the core can fetch an operand and retire a result in the same cycle.

Any access to address 00h is redirected to the location named by the low five bits of the pointer register. Several special locations carry fixed bits that read as one or zero whatever was written, and each has a defined power-on value. The block drives the page-select bit to the program sequencer. A write that lands on the program-counter slot produces a strobe and data for the sequencer rather than being stored here.

Top module: `dspace_regfile`

## Requirements
- R1: After reset, reads return 18h at 03h (status), E0h at 04h (pointer), F0h at 05h (port A) and 00h at 06h (port B); `page_sel`, `porta_q` and `portb_q` are 0.
- R2: A byte written to any address 07h..1Fh is read back unchanged at that address from the cycle after the write edge.
- R3: An access to address 00h reads or writes the location whose address is the pointer register bits 4..0.
- R4: Address 01h, and an access to 00h while the pointer names 00h or 01h, reads 00h; writes there change no location.
- R5: Status bit 4 always reads 1 and bit 6 always reads 0; bits 0,1,2,3,5,7 hold the written value; `page_sel` equals status bit 5.
- R6: Pointer register bits 7..5 always read 1; only bits 4..0 are stored.
- R7: Port A bits 7..4 always read 1 and bits 3..0 are stored and driven on `porta_q`; port B stores all 8 bits and drives them on `portb_q`.
- R8: A read of 02h returns `pc_lo_in`; a write reaching 02h (directly or through the pointer) raises `pc_wr` in the same cycle with `pc_wr_data` equal to the written byte, and stores nothing.
- R9: When the read and write addresses match in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| raddr | input | 5 | Read address |
| rdata | output | 8 | Combinational read data |
| we | input | 1 | Write enable |
| waddr | input | 5 | Write address |
| wdata | input | 8 | Write data |
| pc_lo_in | input | 8 | Current program-counter low byte from the sequencer |
| pc_wr | output | 1 | Strobe: a write targeted the program-counter slot |
| pc_wr_data | output | 8 | Byte to load into the program-counter low byte |
| page_sel | output | 1 | Program page select (status bit 5) |
| porta_q | output | 4 | Port A data latch |
| portb_q | output | 8 | Port B data latch |

## Verification
A corrupted pointer shows immediately at the ports: the next read of 00h returns a byte from the wrong location, so every indirect read after a pointer write is compared against the byte last stored at the intended target. A lost or misdirected write appears on the first read-back of that location one cycle later, and a write that leaks into the null slots shows up as a changed pointer or RAM byte on the following read. Fixed bits and the strobe are combinational, so a fault there is visible in the same cycle as the access.

// File: rtl/dspace_regfile.sv
module dspace_regfile #(
  parameter int DW     = 8,
  parameter int AW     = 5,
  parameter int RAM_LO = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pc_lo_in,
  output logic          pc_wr,
  output logic [DW-1:0] pc_wr_data,
  output logic          page_sel,
  output logic [3:0]    porta_q,
  output logic [DW-1:0] portb_q
);
  localparam int NLOC = 1 << AW;
  localparam logic [AW-1:0] A_IND = AW'(0);
  localparam logic [AW-1:0] A_PC  = AW'(2);
  localparam logic [AW-1:0] A_ST  = AW'(3);
  localparam logic [AW-1:0] A_PTR = AW'(4);
  localparam logic [AW-1:0] A_PA  = AW'(5);
  localparam logic [AW-1:0] A_PB  = AW'(6);
  localparam logic [AW-1:0] A_LO  = AW'(RAM_LO);

  logic [DW-1:0] ram [RAM_LO:NLOC-1];
  logic [DW-1:0] status_q;
  logic [AW-1:0] ptr_q;
  logic [3:0]    pa_q;
  logic [DW-1:0] pb_q;

  logic [AW-1:0] eff_r, eff_w;
  logic          null_r, null_w, wr_ok;

  assign eff_r  = (raddr == A_IND) ? ptr_q : raddr;
  assign eff_w  = (waddr == A_IND) ? ptr_q : waddr;
  assign null_r = eff_r < A_PC;
  assign null_w = eff_w < A_PC;
  assign wr_ok  = we && !null_w;

  assign pc_wr      = wr_ok && (eff_w == A_PC);
  assign pc_wr_data = wdata;
  assign page_sel   = status_q[5];
  assign porta_q    = pa_q;
  assign portb_q    = pb_q;

  always_comb begin
    rdata = '0;
    if (!null_r) begin
      case (eff_r)
        A_PC:    rdata = pc_lo_in;
        A_ST:    rdata = {status_q[7], 1'b0, status_q[5], 1'b1, status_q[3:0]};
        A_PTR:   rdata = {{(DW-AW){1'b1}}, ptr_q};
        A_PA:    rdata = {4'hF, pa_q};
        A_PB:    rdata = pb_q;
        default: rdata = ram[eff_r];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 8'h18;
      ptr_q    <= '0;
      pa_q     <= '0;
      pb_q     <= '0;
    end else if (wr_ok) begin
      case (eff_w)
        A_ST:  status_q <= wdata;
        A_PTR: ptr_q    <= wdata[AW-1:0];
        A_PA:  pa_q     <= wdata[3:0];
        A_PB:  pb_q     <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok && eff_w >= A_LO) ram[eff_w] <= wdata;
  end

  AST_RAM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && eff_w >= A_LO) |=> ram[$past(eff_w)] == $past(wdata)); // R2
  AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    null_r |-> rdata == '0); // R4
  AST_NULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && null_w) |=> $stable(ptr_q) && $stable(status_q) && $stable(pb_q)); // R4
  AST_STATUS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_r == A_ST) |-> rdata[4] && !rdata[6]); // R5
  AST_PTR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_r == A_PTR) |-> rdata[DW-1:AW] == '1); // R6
  AST_PA_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (eff_r == A_PA) |-> rdata[7:4] == 4'hF); // R7
  AST_PC_NOSTORE: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |=> $stable(status_q) && $stable(ptr_q) && $stable(pa_q) && $stable(pb_q)); // R8
endmodule

// File: tb/tb_dspace_regfile.sv
module tb_dspace_regfile;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [4:0] raddr = 0, waddr = 0;
  logic [7:0] wdata = 0, pc_lo_in = 8'h81;
  logic       we = 0;
  logic [7:0] rdata, pc_wr_data, portb_q;
  logic       pc_wr, page_sel;
  logic [3:0] porta_q;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dspace_regfile dut (
    .clk(clk), .rst_n(rst_n), .raddr(raddr), .rdata(rdata), .we(we),
    .waddr(waddr), .wdata(wdata), .pc_lo_in(pc_lo_in), .pc_wr(pc_wr),
    .pc_wr_data(pc_wr_data), .page_sel(page_sel), .porta_q(porta_q),
    .portb_q(portb_q)
  );

  // {is_write, req, addr, data, expected}
  localparam int NV = 33;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 4'd2, 5'h07, 8'hA5, 8'h00}, // R2
    {1'b1, 4'd2, 5'h1F, 8'h3C, 8'h00}, // R2
    {1'b0, 4'd2, 5'h07, 8'h00, 8'hA5}, // R2
    {1'b0, 4'd2, 5'h1F, 8'h00, 8'h3C}, // R2
    {1'b1, 4'd2, 5'h10, 8'hFF, 8'h00}, // R2
    {1'b0, 4'd2, 5'h10, 8'h00, 8'hFF}, // R2
    {1'b1, 4'd3, 5'h04, 8'h10, 8'h00}, // R3
    {1'b0, 4'd6, 5'h04, 8'h00, 8'hF0}, // R6
    {1'b0, 4'd3, 5'h00, 8'h00, 8'hFF}, // R3
    {1'b1, 4'd3, 5'h00, 8'h5A, 8'h00}, // R3
    {1'b0, 4'd3, 5'h10, 8'h00, 8'h5A}, // R3
    {1'b1, 4'd6, 5'h04, 8'hFF, 8'h00}, // R6
    {1'b0, 4'd6, 5'h04, 8'h00, 8'hFF}, // R6
    {1'b0, 4'd3, 5'h00, 8'h00, 8'h3C}, // R3
    {1'b1, 4'd4, 5'h04, 8'h01, 8'h00}, // R4
    {1'b0, 4'd4, 5'h00, 8'h00, 8'h00}, // R4
    {1'b1, 4'd4, 5'h00, 8'h77, 8'h00}, // R4
    {1'b0, 4'd4, 5'h01, 8'h00, 8'h00}, // R4
    {1'b1, 4'd4, 5'h01, 8'h66, 8'h00}, // R4
    {1'b0, 4'd4, 5'h04, 8'h00, 8'hE1}, // R4
    {1'b1, 4'd4, 5'h04, 8'h00, 8'h00}, // R4
    {1'b1, 4'd4, 5'h00, 8'h99, 8'h00}, // R4
    {1'b0, 4'd4, 5'h04, 8'h00, 8'hE0}, // R4
    {1'b1, 4'd5, 5'h03, 8'hFF, 8'h00}, // R5
    {1'b0, 4'd5, 5'h03, 8'h00, 8'hBF}, // R5
    {1'b1, 4'd5, 5'h03, 8'h00, 8'h00}, // R5
    {1'b0, 4'd5, 5'h03, 8'h00, 8'h10}, // R5
    {1'b1, 4'd7, 5'h05, 8'hFF, 8'h00}, // R7
    {1'b0, 4'd7, 5'h05, 8'h00, 8'hFF}, // R7
    {1'b1, 4'd7, 5'h05, 8'h0A, 8'h00}, // R7
    {1'b0, 4'd7, 5'h05, 8'h00, 8'hFA}, // R7
    {1'b1, 4'd7, 5'h06, 8'hC3, 8'h00}, // R7
    {1'b0, 4'd7, 5'h06, 8'h00, 8'hC3}  // R7
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; waddr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); raddr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset values
    rd("R1", 5'h03, 8'h18);
    rd("R1", 5'h04, 8'hE0);
    rd("R1", 5'h05, 8'hF0);
    rd("R1", 5'h06, 8'h00);
    chk("R1", {7'd0, page_sel}, 8'h00);
    chk("R1", {4'd0, porta_q}, 8'h00);
    chk("R1", portb_q, 8'h00);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[i][24:21]);
      if (VEC[i][25]) wr(VEC[i][20:16], VEC[i][15:8]);
      else rd(tag, VEC[i][20:16], VEC[i][7:0]);
    end

    // R7 port outputs
    chk("R7", {4'd0, porta_q}, 8'h0A);
    chk("R7", portb_q, 8'hC3);

    // R5 page select follows status bit 5
    wr(5'h03, 8'h20);
    chk("R5", {7'd0, page_sel}, 8'h01);
    rd("R5", 5'h03, 8'h30);
    wr(5'h03, 8'h08);
    chk("R5", {7'd0, page_sel}, 8'h00);
    rd("R5", 5'h03, 8'h18);

    // R8 program-counter slot
    rd("R8", 5'h02, 8'h81);
    @(negedge clk); we = 1; waddr = 5'h02; wdata = 8'h5C; #1;
    chk("R8", {7'd0, pc_wr}, 8'h01);
    chk("R8", pc_wr_data, 8'h5C);
    @(negedge clk); we = 0; #1;
    chk("R8", {7'd0, pc_wr}, 8'h00);
    wr(5'h04, 8'h02);
    rd("R8", 5'h00, 8'h81);
    @(negedge clk); we = 1; waddr = 5'h00; wdata = 8'h3E; #1;
    chk("R8", {7'd0, pc_wr}, 8'h01);
    chk("R8", pc_wr_data, 8'h3E);
    @(negedge clk); we = 0;
    rd("R8", 5'h04, 8'hE2);
    rd("R8", 5'h03, 8'h18);

    // R9 read during write returns old value
    wr(5'h08, 8'h22);
    @(negedge clk); we = 1; waddr = 5'h08; wdata = 8'h11; raddr = 5'h08; #1;
    chk("R9", rdata, 8'h22);
    @(negedge clk); we = 0; #1;
    chk("R9", rdata, 8'h11);

    // R4 write to 01h leaves neighbours untouched
    wr(5'h01, 8'hAA);
    rd("R4", 5'h04, 8'hE2);
    rd("R4", 5'h07, 8'hA5);

    finish_up();
  end
endmodule